// File: doc/BRIEF.md
# Dual-Personality Serial Port (Async USART / SPI Master)

This block is a byte-wide serial port with two personalities built on one datapath. With the mode field at any code other than `2'b11`, it sends and receives minimal asynchronous frames: one low start bit, eight data bits LSB first, and one high stop bit. In this mode the transmit line is `mosi` and the receive line is `miso`. With the mode field at `2'b11`, the same shift registers, one-entry transmit buffer, receive buffer and half-bit timer are driven instead by a single transfer controller that acts as an SPI master. This controller always generates `sck` from the internal divisor.

Software-style access is one flat register set that does not change with mode: a configuration word (mode, enables, clock polarity, clock phase, divisor), a write strobe that loads the transmit buffer, and a read strobe that acknowledges the receive buffer. Two sticky flags report a finished transmission and a newly received byte. A second byte may be written while the first is still shifting, and the two then go out with no gap on `sck`.

Timing is set by the divisor `D`. Every half-bit lasts `D+1` clocks, so one bit takes `2*(D+1)` clocks in both personalities.

Top module: `serial_dual_port`

## Requirements
- R1: After reset `rd_data` is 0, both flags are 0, `tx_empty` is 1, `mosi` is 1, and with mode `2'b00` `sck` is 0.
- R2: SPI master operation is selected only when `cfg_mode == 2'b11`. Codes `2'b00`, `2'b01` and `2'b10` give asynchronous framing, with `sck` held at 0.
- R3: In SPI mode a written byte leaves on `mosi` MSB first as exactly 8 bits. Each bit is held for a full bit time and changes only at bit boundaries.
- R4: In SPI mode `sck` rests at `cfg_cpol` whenever no byte is shifting. It makes 16 transitions per byte, and each level lasts `cfg_div+1` clocks.
- R5: During the first half of each bit, `sck` equals `cfg_cpol ^ cfg_cpha`. `miso` is sampled on the `sck` edge in the middle of the bit, and `mosi` changes on the other edge. This gives the four polarity/phase combinations.
- R6: The byte shifted in from `miso` (MSB first) appears on `rd_data` with `rxc_flag` set when the byte ends. A read strobe clears `rxc_flag`.
- R7: `rxc_flag` and `txc_flag` become visible `16*(cfg_div+1)+1` clocks after the clock edge that accepts the write of a lone SPI byte.
- R8: `txc_flag` is set only when a frame ends with the transmit buffer empty. An accepted write clears it, and `tx_empty` shows whether the buffer can take a byte.
- R9: A byte written while another is shifting follows back to back. `sck` makes 32 transitions, and `txc_flag` first appears `32*(cfg_div+1)+1` clocks after the first write.
- R10: With `cfg_txen` low, writes are ignored: `tx_empty` stays 1, `txc_flag` keeps its value, `sck` does not move, and re-enabling starts nothing.
- R11: With `cfg_rxen` low, an SPI transfer still runs but `rd_data` keeps its value and `rxc_flag` stays 0.
- R12: In asynchronous mode a written byte goes out as a frame on `mosi`: bit 0 low, bits 1..8 the data LSB first, bit 9 high, each bit `2*(cfg_div+1)` clocks wide. `mosi` idles high. The receiver on `miso` decodes such a frame into `rd_data` and sets `rxc_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | Personality select; `2'b11` is SPI master |
| cfg_txen | input | 1 | Transmitter enable |
| cfg_rxen | input | 1 | Receiver enable |
| cfg_cpol | input | 1 | SCK resting level in SPI mode |
| cfg_cpha | input | 1 | SCK phase in SPI mode |
| cfg_div | input | DIV_W | Half-bit divisor; half-bit = cfg_div+1 clocks |
| wr_en | input | 1 | Write strobe for the transmit buffer |
| wr_data | input | DATA_W | Byte to transmit |
| rd_en | input | 1 | Read strobe, clears the receive flag |
| rd_data | output | DATA_W | Receive buffer |
| tx_empty | output | 1 | Transmit buffer can accept a byte |
| txc_flag | output | 1 | Transmission complete |
| rxc_flag | output | 1 | Receive complete |
| sck | output | 1 | Serial clock (SPI mode) |
| mosi | output | 1 | Serial data out / async transmit line |
| miso | input | 1 | Serial data in / async receive line |

## Verification
The assertions assume that the configuration word (mode, enables, polarity, phase, divisor) is held steady whenever a byte is in flight or buffered. A change there would corrupt the transfer by design, so the flag and resting-level properties would not be meaningful. The stimulus changes configuration only while `txc_flag` shows the engine idle, and then waits several clocks before the next write. It writes a second byte only when `tx_empty` is high. The bench's SPI slave is re-armed after every configuration change, so a resting-level move of `sck` is never counted as a data edge.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
   localparam logic [1:0] MODE_SPI = 2'b11;

   function automatic logic is_spi(input logic [1:0] m);
      return m == MODE_SPI;
   endfunction
endpackage

// File: rtl/sdp_half_timer.sv
// Counts half-bit periods of (div+1) clocks while run is high.
module sdp_half_timer #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             half_end
);
   logic [DIV_W-1:0] cnt;

   assign half_end = run && (cnt == div);

   always_ff @(posedge clk) begin
      if (!rst_n)           cnt <= '0;
      else if (!run)        cnt <= '0;
      else if (cnt == div)  cnt <= '0;
      else                  cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/sdp_xfer.sv
// Common transfer controller: drives the shared shift registers in
// either SPI-master or asynchronous-transmit personality.
module sdp_xfer #(
   parameter int DATA_W = 8,
   parameter int DIV_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi,
   input  logic              cpol,
   input  logic              cpha,
   input  logic [DIV_W-1:0]  div,
   input  logic              en,
   input  logic              have_next,
   input  logic [DATA_W-1:0] next_data,
   input  logic              miso,
   output logic              take,
   output logic              fin,
   output logic [DATA_W-1:0] rx_word,
   output logic              sck,
   output logic              mosi
);
   localparam int BIT_W = $clog2(DATA_W + 2);

   logic              busy, half, half_end;
   logic [BIT_W-1:0]  bitn, last_bit;
   logic [DATA_W-1:0] tx_sr, rx_sr;

   sdp_half_timer #(.DIV_W(DIV_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .run(busy), .div(div), .half_end(half_end)
   );

   assign last_bit = spi ? BIT_W'(DATA_W - 1) : BIT_W'(DATA_W + 1);
   assign fin      = busy && half_end && half && (bitn == last_bit);
   assign take     = en && have_next && (!busy || fin);
   assign rx_word  = rx_sr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         half  <= 1'b0;
         bitn  <= '0;
         tx_sr <= '0;
         rx_sr <= '0;
      end else if (take) begin
         busy  <= 1'b1;
         half  <= 1'b0;
         bitn  <= '0;
         tx_sr <= next_data;
      end else if (fin) begin
         busy <= 1'b0;
         half <= 1'b0;
      end else if (busy && half_end) begin
         if (!half) begin
            half <= 1'b1;
            if (spi) rx_sr <= {rx_sr[DATA_W-2:0], miso};
         end else begin
            half <= 1'b0;
            bitn <= bitn + 1'b1;
            if (spi)            tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
            else if (bitn != 0) tx_sr <= {1'b0, tx_sr[DATA_W-1:1]};
         end
      end
   end

   always_comb begin
      if (!spi)      sck = 1'b0;
      else if (busy) sck = cpol ^ cpha ^ half;
      else           sck = cpol;

      if (!busy)                mosi = 1'b1;
      else if (spi)             mosi = tx_sr[DATA_W-1];
      else if (bitn == 0)       mosi = 1'b0;
      else if (bitn == last_bit) mosi = 1'b1;
      else                      mosi = tx_sr[0];
   end
endmodule

// File: rtl/sdp_arx.sv
// Minimal asynchronous receiver: start-bit check at its centre,
// data sampled at bit centres LSB first, frame kept only on a high stop bit.
module sdp_arx #(
   parameter int DATA_W = 8,
   parameter int DIV_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [DIV_W-1:0]  div,
   input  logic              rxd,
   output logic              valid,
   output logic [DATA_W-1:0] word
);
   localparam int STOP_H = 2 * DATA_W + 2;
   localparam int HN_W   = $clog2(STOP_H + 1);

   logic              s1, s2, busy, half_end;
   logic [HN_W-1:0]   hn;
   logic [DATA_W-1:0] sr;

   sdp_half_timer #(.DIV_W(DIV_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .run(busy), .div(div), .half_end(half_end)
   );

   assign word = sr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1    <= 1'b1;
         s2    <= 1'b1;
         busy  <= 1'b0;
         hn    <= '0;
         sr    <= '0;
         valid <= 1'b0;
      end else begin
         s1    <= rxd;
         s2    <= s1;
         valid <= 1'b0;
         if (!en) begin
            busy <= 1'b0;
         end else if (!busy) begin
            if (!s2) begin
               busy <= 1'b1;
               hn   <= '0;
            end
         end else if (half_end) begin
            hn <= hn + 1'b1;
            if (hn == 0) begin
               if (s2) busy <= 1'b0;
            end else if (hn == HN_W'(STOP_H)) begin
               busy  <= 1'b0;
               valid <= s2;
            end else if (!hn[0]) begin
               sr <= {s2, sr[DATA_W-1:1]};
            end
         end
      end
   end
endmodule

// File: rtl/serial_dual_port.sv
module serial_dual_port #(
   parameter int DATA_W   = 8,
   parameter int DIV_W    = 8,
   parameter bit ASYNC_RX = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cfg_mode,
   input  logic              cfg_txen,
   input  logic              cfg_rxen,
   input  logic              cfg_cpol,
   input  logic              cfg_cpha,
   input  logic [DIV_W-1:0]  cfg_div,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              tx_empty,
   output logic              txc_flag,
   output logic              rxc_flag,
   output logic              sck,
   output logic              mosi,
   input  logic              miso
);
   import sdp_pkg::*;

   if (DATA_W < 4 || DIV_W < 1) begin : g_bad_param
      $error("serial_dual_port: DATA_W must be >= 4 and DIV_W >= 1");
   end

   logic              spi, wr_ok;
   logic              buf_full;
   logic [DATA_W-1:0] buf_data, eng_word, arx_word, rx_data_in;
   logic              take, fin, arx_valid, rx_load;

   assign spi      = is_spi(cfg_mode);
   assign wr_ok    = wr_en && cfg_txen;
   assign tx_empty = !buf_full;

   sdp_xfer #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_xfer (
      .clk(clk), .rst_n(rst_n), .spi(spi), .cpol(cfg_cpol), .cpha(cfg_cpha),
      .div(cfg_div), .en(cfg_txen), .have_next(buf_full), .next_data(buf_data),
      .miso(miso), .take(take), .fin(fin), .rx_word(eng_word),
      .sck(sck), .mosi(mosi)
   );

   if (ASYNC_RX) begin : g_arx
      sdp_arx #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_arx (
         .clk(clk), .rst_n(rst_n), .en(cfg_rxen && !spi), .div(cfg_div),
         .rxd(miso), .valid(arx_valid), .word(arx_word)
      );
   end else begin : g_no_arx
      assign arx_valid = 1'b0;
      assign arx_word  = '0;
   end

   assign rx_load    = cfg_rxen && (spi ? fin : arx_valid);
   assign rx_data_in = spi ? eng_word : arx_word;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         buf_full <= 1'b0;
         buf_data <= '0;
         txc_flag <= 1'b0;
         rxc_flag <= 1'b0;
         rd_data  <= '0;
      end else begin
         if (take) buf_full <= 1'b0;
         if (wr_ok && (!buf_full || take)) begin
            buf_full <= 1'b1;
            buf_data <= wr_data;
         end

         if (fin && !take) txc_flag <= 1'b1;
         else if (wr_ok)   txc_flag <= 1'b0;

         if (rx_load) begin
            rd_data  <= rx_data_in;
            rxc_flag <= 1'b1;
         end else if (rd_en) begin
            rxc_flag <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/sdp_checker.sv
module sdp_checker #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        cfg_mode,
   input logic              cfg_txen,
   input logic              cfg_rxen,
   input logic              cfg_cpol,
   input logic              rd_en,
   input logic [DATA_W-1:0] rd_data,
   input logic              tx_empty,
   input logic              txc_flag,
   input logic              rxc_flag,
   input logic              sck,
   input logic              mosi,
   input logic              rx_load,
   input logic [DATA_W-1:0] rx_data_in
);
   AST_ASYNC_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mode != 2'b11) |-> !sck); // R2
   AST_SCK_RESTS: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mode == 2'b11 && txc_flag) |-> (sck == cfg_cpol)); // R4
   AST_RX_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      rx_load |=> (rxc_flag && rd_data == $past(rx_data_in))); // R6
   AST_RX_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !rx_load) |=> !rxc_flag); // R6
   AST_TXC_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(txc_flag) |-> tx_empty); // R8
   AST_TX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_txen && tx_empty) |=> tx_empty); // R10
   AST_RX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_rxen |=> $stable(rd_data)); // R11
   AST_ASYNC_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mode != 2'b11 && txc_flag) |-> mosi); // R12
endmodule

bind serial_dual_port sdp_checker #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_txen(cfg_txen),
   .cfg_rxen(cfg_rxen), .cfg_cpol(cfg_cpol), .rd_en(rd_en), .rd_data(rd_data),
   .tx_empty(tx_empty), .txc_flag(txc_flag), .rxc_flag(rxc_flag), .sck(sck),
   .mosi(mosi), .rx_load(rx_load), .rx_data_in(rx_data_in)
);

// File: tb/sim_serial_dual_port.sv
module sim_serial_dual_port;
   localparam int CLK_P = 10;
   localparam int LIMIT = 2000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] cfg_mode = 2'b00;
   logic       cfg_txen = 1'b0, cfg_rxen = 1'b0, cfg_cpol = 1'b0, cfg_cpha = 1'b0;
   logic [7:0] cfg_div = 8'd0;
   logic       wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0] wr_data = 8'd0;
   logic [7:0] rd_data;
   logic       tx_empty, txc_flag, rxc_flag, sck, mosi, miso;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   // bench SPI slave
   bit          armed = 1'b0;
   bit          loop = 1'b0;
   logic [15:0] s_stream = '0;
   logic [15:0] m_cap = '0;
   int          edges = 0;

   assign miso = loop ? mosi : s_stream[15];

   always #(CLK_P/2) clk = ~clk;

   serial_dual_port u0 (
      .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_txen(cfg_txen),
      .cfg_rxen(cfg_rxen), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
      .cfg_div(cfg_div), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
      .rd_data(rd_data), .tx_empty(tx_empty), .txc_flag(txc_flag),
      .rxc_flag(rxc_flag), .sck(sck), .mosi(mosi), .miso(miso)
   );

   always @(sck) begin
      if (armed) begin
         edges++;
         if (sck == ~(cfg_cpol ^ cfg_cpha)) begin
            m_cap    = {m_cap[14:0], mosi};
            s_stream = {s_stream[14:0], 1'b0};
         end
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // called at a negedge; returns at the negedge after the accepting edge
   task automatic write_byte(input logic [7:0] d);
      wr_en = 1'b1;
      wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic read_ack();
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic arm(input logic [7:0] a, input logic [7:0] b);
      s_stream = {a, b};
      m_cap    = '0;
      edges    = 0;
      armed    = 1'b1;
   endtask

   task automatic setup_spi(input logic cp, input logic ch, input logic [7:0] d);
      armed = 1'b0;
      loop = 1'b0;
      cfg_mode = 2'b11; cfg_cpol = cp; cfg_cpha = ch; cfg_div = d;
      cfg_txen = 1'b1; cfg_rxen = 1'b1;
      repeat (4) @(negedge clk);
      read_ack();
   endtask

   task automatic t_reset();
      chk(rd_data == 8'h00, "R1 rd_data", 32'(rd_data), 0);
      chk(!txc_flag && !rxc_flag, "R1 flags", {30'd0, txc_flag, rxc_flag}, 0);
      chk(tx_empty, "R1 tx_empty", 32'(tx_empty), 1);
      chk(mosi && !sck, "R1 pins", {30'd0, mosi, sck}, 2);
   endtask

   task automatic t_spi_byte(input logic cp, input logic ch, input logic [7:0] d,
                             input logic [7:0] tx, input logic [7:0] sl);
      int n;
      setup_spi(cp, ch, d);
      arm(sl, 8'h00);
      chk(sck == cp, "R4 idle level", 32'(sck), 32'(cp));
      write_byte(tx);
      @(negedge clk);
      n = 1;
      chk(sck == (cp ^ ch), "R5 first half level", 32'(sck), 32'(cp ^ ch));
      while (!rxc_flag && n < LIMIT) begin @(negedge clk); n++; end
      chk(n == 16 * (d + 1) + 1, "R7 latency", n, 16 * (d + 1) + 1);
      chk(txc_flag, "R8 txc set", 32'(txc_flag), 1);
      chk(m_cap[7:0] == tx, "R3 mosi byte", 32'(m_cap[7:0]), 32'(tx));
      chk(rd_data == sl, "R6 rx byte", 32'(rd_data), 32'(sl));
      chk(edges == 16, "R4 edge count", edges, 16);
      chk(sck == cp, "R4 rest after", 32'(sck), 32'(cp));
      read_ack();
      chk(!rxc_flag, "R6 rxc cleared", 32'(rxc_flag), 0);
   endtask

   task automatic t_back2back(input logic [7:0] d);
      int n;
      setup_spi(1'b0, 1'b1, d);
      arm(8'h3C, 8'hD2);
      write_byte(8'h81);
      @(negedge clk);
      n = 1;
      chk(tx_empty && !txc_flag, "R8 buffer taken", {30'd0, tx_empty, txc_flag}, 2);
      write_byte(8'h7E);
      n++;
      while (!txc_flag && n < LIMIT) begin @(negedge clk); n++; end
      chk(n == 32 * (d + 1) + 1, "R9 gapless latency", n, 32 * (d + 1) + 1);
      chk(m_cap == 16'h817E, "R9 two bytes out", 32'(m_cap), 32'h817E);
      chk(edges == 32, "R9 edge count", edges, 32);
      chk(rd_data == 8'hD2, "R9 second rx", 32'(rd_data), 32'hD2);
   endtask

   task automatic t_txen_off();
      setup_spi(1'b1, 1'b0, 8'd1);
      cfg_txen = 1'b0;
      arm(8'h00, 8'h00);
      write_byte(8'h55);
      repeat (40) @(negedge clk);
      chk(tx_empty, "R10 buffer unchanged", 32'(tx_empty), 1);
      chk(txc_flag, "R10 txc kept", 32'(txc_flag), 1);
      chk(edges == 0, "R10 sck quiet", edges, 0);
      cfg_txen = 1'b1;
      repeat (40) @(negedge clk);
      chk(edges == 0 && tx_empty, "R10 nothing started", edges, 0);
   endtask

   task automatic t_rxen_off();
      int n;
      logic [7:0] prev;
      setup_spi(1'b0, 1'b0, 8'd2);
      prev = rd_data;
      cfg_rxen = 1'b0;
      arm(~prev, 8'h00);
      write_byte(8'hC3);
      n = 0;
      while (!txc_flag && n < LIMIT) begin @(negedge clk); n++; end
      chk(m_cap[7:0] == 8'hC3, "R11 tx still runs", 32'(m_cap[7:0]), 32'hC3);
      chk(rd_data == prev, "R11 rd_data kept", 32'(rd_data), 32'(prev));
      chk(!rxc_flag, "R11 rxc quiet", 32'(rxc_flag), 0);
   endtask

   task automatic t_async(input logic [1:0] m, input logic [7:0] d, input logic [7:0] b);
      int k, n;
      logic [9:0] fr, exp_fr;
      armed = 1'b0;
      loop = 1'b1;
      cfg_mode = m; cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_div = d;
      cfg_txen = 1'b1; cfg_rxen = 1'b1;
      repeat (30) @(negedge clk);
      read_ack();
      chk(mosi, "R12 idle high", 32'(mosi), 1);
      write_byte(b);
      k = 0;
      for (int i = 0; i < 10; i++) begin
         while (k < 1 + (2 * i + 1) * (d + 1)) begin @(negedge clk); k++; end
         fr[i] = mosi;
         if (sck) chk(1'b0, "R2 sck low in async", 32'(sck), 0);
      end
      exp_fr = {1'b1, b, 1'b0};
      chk(fr == exp_fr, "R12 frame bits", 32'(fr), 32'(exp_fr));
      n = 0;
      while (!rxc_flag && n < LIMIT) begin @(negedge clk); n++; end
      chk(rd_data == b, "R12 loopback rx", 32'(rd_data), 32'(b));
      n = 0;
      while (!txc_flag && n < LIMIT) begin @(negedge clk); n++; end
      chk(txc_flag && mosi, "R2 async frame done", {30'd0, txc_flag, mosi}, 3);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_spi_byte(1'b0, 1'b0, 8'd0, 8'hA5, 8'h5A);
      t_spi_byte(1'b0, 1'b1, 8'd1, 8'h96, 8'hF0);
      t_spi_byte(1'b1, 1'b0, 8'd3, 8'h01, 8'h80);
      t_spi_byte(1'b1, 1'b1, 8'd2, 8'hE7, 8'h3B);
      t_back2back(8'd1);
      t_txen_off();
      t_rxen_off();
      t_async(2'b00, 8'd3, 8'hA5);
      t_async(2'b01, 8'd1, 8'h6C);
      t_async(2'b10, 8'd2, 8'h13);
      if (!finished) begin
         finished = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule